// File: doc/BRIEF.md
# Prioritized Reset Cause Resolver

This block settles which of several simultaneous reset requests governs one switch partition and its ports. Eight request levels enter as already-decoded signals. They range from a device-wide fundamental reset down to a secondary bus reset aimed at individual downstream ports. Each request passes through a synchronizer. A fixed-priority arbiter then selects one winner, and a registered output stage reports four things: the winning cause, the reset type that cause implies, the scope it reaches (device, partition or single ports) and a per-port reset vector.

When the winning request ends while a weaker one is still present, control passes straight to the weaker one. If both imply the same reset type, the reset stays asserted on every cycle. If the types differ, the reported type switches in the cycle the stronger request's effect ends, and a one-cycle type-change pulse is emitted so that downstream sequencing can restart. A separate one-cycle strobe clears switch-sticky register bits. Only the device-wide fundamental reset produces this strobe.

Top module: `rst_cause_resolver`

## Requirements
- R1: The cause index on `win_cause` is the lowest-numbered active cause, with this numbering: 0 device fundamental, 1 qualified port mode change, 2 partition reset pin, 3 partition control-state reset, 4 hot reset from training sets, 5 hot reset from link-layer down, 6 upstream secondary bus reset, 7 downstream secondary bus reset. `win_valid` is high exactly when some cause is active.
- R2: `rst_type` encodes 00 none, 01 fundamental (causes 0 to 3), 10 hot (causes 4 and 5), 11 secondary bus (causes 6 and 7).
- R3: `rst_scope` encodes 00 none, 01 port, 10 partition, 11 device. Cause 0 is device scope, causes 1 and 7 are port scope, and causes 2 to 6 are partition scope. `port_rst` is all ones for device and partition scope. For cause 1 it equals the qualified mode-change vector, and for cause 7 it equals the `dn_sbr_req` vector.
- R4: A port's mode change counts as cause 1 only while both `port_mode_chg` and `port_mode_rst_sel` are high for that port. A mode change without the reset selection leaves every output at its idle value.
- R5: A request change driven before rising edge k shows on the outputs after rising edge k+2 and not earlier.
- R6: When the winner ends and the next active cause has the same reset type, `win_valid` stays high and `rst_type` stays unchanged on every cycle, and `type_chg` stays low.
- R7: When the winner ends and the next active cause has a different reset type, `rst_type` takes the new type in the cycle the new winner is reported, and `type_chg` is high for exactly that one cycle.
- R8: `type_chg` stays low when a reset begins from the idle state and when it ends to the idle state.
- R9: `sticky_clr` is a one-cycle pulse in the first cycle that cause 0 is reported, whether it arrives from idle or pre-empts another cause. No other cause ever raises it.
- R10: While `rst_n` is low, all outputs are zero.
- R11: Once every request has been removed for three edges, all outputs return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the resolver itself |
| dev_fund_req | input | 1 | Device-wide fundamental reset request (cause 0) |
| port_mode_chg | input | NPORTS | Per-port operating-mode change in progress |
| port_mode_rst_sel | input | NPORTS | Per-port mode-action selects port reset |
| part_pin_req | input | 1 | Partition reset pin request (cause 2) |
| part_ctl_req | input | 1 | Partition control-state reset request (cause 3) |
| hot_ts_req | input | 1 | Hot reset seen in training sets (cause 4) |
| hot_dl_req | input | 1 | Upstream link layer went down (cause 5) |
| up_sbr_req | input | 1 | Upstream secondary bus reset bit (cause 6) |
| dn_sbr_req | input | NPORTS | Per-port downstream secondary bus reset bits (cause 7) |
| win_valid | output | 1 | Some reset cause is in effect |
| win_cause | output | 3 | Index of the winning cause |
| rst_type | output | 2 | Reset type of the winner |
| rst_scope | output | 2 | Scope reached by the winner |
| port_rst | output | NPORTS | Ports held in reset |
| sticky_clr | output | 1 | One-cycle clear strobe for switch-sticky bits |
| type_chg | output | 1 | One-cycle pulse when the type changes while reset holds |

## Verification
An arbiter that settles on the wrong winner shows up as a wrong `win_cause` and usually a wrong `rst_type` or `port_rst`. This appears three edges after the request pattern changes, so every handover is checked at exactly that cycle. A stale copy of the previously reported type in the output stage shows up in a different way: a missing or extra `type_chg` pulse, or a spurious `sticky_clr`, in the very cycle of the handover. Same-type handovers are therefore sampled on every cycle to catch a one-cycle release. A broken synchronizer depth moves the first visible response one edge earlier or later, and the latency check catches that.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  localparam int unsigned NCAUSE = 8;
  localparam int unsigned CIDX_W = $clog2(NCAUSE);

  typedef logic [CIDX_W-1:0] cidx_t;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_FUND = 2'b01,
    RT_HOT  = 2'b10,
    RT_SBR  = 2'b11
  } rst_type_e;

  typedef enum logic [1:0] {
    SC_NONE = 2'b00,
    SC_PORT = 2'b01,
    SC_PART = 2'b10,
    SC_DEV  = 2'b11
  } rst_scope_e;

  // cause numbering: lower index is stronger
  localparam cidx_t C_DEV_FUND  = 3'd0;
  localparam cidx_t C_PORT_MODE = 3'd1;
  localparam cidx_t C_PART_PIN  = 3'd2;
  localparam cidx_t C_PART_CTL  = 3'd3;
  localparam cidx_t C_HOT_TS    = 3'd4;
  localparam cidx_t C_HOT_DL    = 3'd5;
  localparam cidx_t C_UP_SBR    = 3'd6;
  localparam cidx_t C_DN_SBR    = 3'd7;

  function automatic rst_type_e type_of(cidx_t c);
    rst_type_e t;
    case (c)
      C_DEV_FUND, C_PORT_MODE, C_PART_PIN, C_PART_CTL: t = RT_FUND;
      C_HOT_TS, C_HOT_DL:                              t = RT_HOT;
      default:                                         t = RT_SBR;
    endcase
    return t;
  endfunction

  function automatic rst_scope_e scope_of(cidx_t c);
    rst_scope_e s;
    case (c)
      C_DEV_FUND:           s = SC_DEV;
      C_PORT_MODE, C_DN_SBR: s = SC_PORT;
      default:              s = SC_PART;
    endcase
    return s;
  endfunction

  function automatic logic held_type_changes(rst_type_e cur, rst_type_e nxt);
    return (cur != RT_NONE) && (nxt != RT_NONE) && (cur != nxt);
  endfunction

endpackage

// File: rtl/rcr_sync.sv
module rcr_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rcr_prio_pick.sv
module rcr_prio_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/rcr_out_stage.sv
module rcr_out_stage
  import rcr_pkg::*;
#(
  parameter int unsigned NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_hit,
  input  cidx_t             arb_idx,
  input  logic [NPORTS-1:0] mode_vec,
  input  logic [NPORTS-1:0] dn_vec,
  output logic              valid_q,
  output cidx_t             cause_q,
  output rst_type_e         type_q,
  output rst_scope_e        scope_q,
  output logic [NPORTS-1:0] ports_q,
  output logic              sticky_q,
  output logic              tchg_q,
  output logic              type_edge,
  output logic              dev_entry
);

  localparam logic [NPORTS-1:0] ALL_PORTS = {NPORTS{1'b1}};

  rst_type_e         nxt_type;
  rst_scope_e        nxt_scope;
  logic [NPORTS-1:0] nxt_ports;

  always_comb begin
    nxt_type  = RT_NONE;
    nxt_scope = SC_NONE;
    nxt_ports = '0;
    if (arb_hit) begin
      nxt_type  = type_of(arb_idx);
      nxt_scope = scope_of(arb_idx);
      if (arb_idx == C_PORT_MODE)   nxt_ports = mode_vec;
      else if (arb_idx == C_DN_SBR) nxt_ports = dn_vec;
      else                          nxt_ports = ALL_PORTS;
    end
  end

  assign type_edge = held_type_changes(type_q, nxt_type);
  assign dev_entry = arb_hit && (arb_idx == C_DEV_FUND)
                     && !(valid_q && (cause_q == C_DEV_FUND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      cause_q  <= '0;
      type_q   <= RT_NONE;
      scope_q  <= SC_NONE;
      ports_q  <= '0;
      sticky_q <= 1'b0;
      tchg_q   <= 1'b0;
    end else begin
      valid_q  <= arb_hit;
      cause_q  <= arb_hit ? arb_idx : '0;
      type_q   <= nxt_type;
      scope_q  <= nxt_scope;
      ports_q  <= nxt_ports;
      sticky_q <= dev_entry;
      tchg_q   <= type_edge;
    end
  end

endmodule

// File: rtl/rst_cause_resolver.sv
module rst_cause_resolver
  import rcr_pkg::*;
#(
  parameter int unsigned NPORTS      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_fund_req,
  input  logic [NPORTS-1:0] port_mode_chg,
  input  logic [NPORTS-1:0] port_mode_rst_sel,
  input  logic              part_pin_req,
  input  logic              part_ctl_req,
  input  logic              hot_ts_req,
  input  logic              hot_dl_req,
  input  logic              up_sbr_req,
  input  logic [NPORTS-1:0] dn_sbr_req,
  output logic              win_valid,
  output logic [2:0]        win_cause,
  output logic [1:0]        rst_type,
  output logic [1:0]        rst_scope,
  output logic [NPORTS-1:0] port_rst,
  output logic              sticky_clr,
  output logic              type_chg
);

  localparam int unsigned NSCALAR = 6;
  localparam int unsigned RAW_W   = NSCALAR + 3 * NPORTS;
  localparam int unsigned CHG_LO  = NSCALAR;
  localparam int unsigned SEL_LO  = NSCALAR + NPORTS;
  localparam int unsigned DN_LO   = NSCALAR + 2 * NPORTS;

  logic [RAW_W-1:0]  raw_req;
  logic [RAW_W-1:0]  sync_req;
  logic [NPORTS-1:0] mode_qual;
  logic [NPORTS-1:0] dn_sync;
  logic [NCAUSE-1:0] cause_req;
  logic              arb_hit;
  cidx_t             arb_idx;
  logic              type_edge;
  logic              dev_entry;

  rst_type_e  type_q;
  rst_scope_e scope_q;
  cidx_t      cause_q;

  assign raw_req = {dn_sbr_req, port_mode_rst_sel, port_mode_chg,
                    up_sbr_req, hot_dl_req, hot_ts_req,
                    part_ctl_req, part_pin_req, dev_fund_req};

  rcr_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_req),
    .q     (sync_req)
  );

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assign mode_qual[p] = sync_req[CHG_LO + p] & sync_req[SEL_LO + p];
      assign dn_sync[p]   = sync_req[DN_LO + p];
    end
  endgenerate

  assign cause_req[C_DEV_FUND]  = sync_req[0];
  assign cause_req[C_PORT_MODE] = |mode_qual;
  assign cause_req[C_PART_PIN]  = sync_req[1];
  assign cause_req[C_PART_CTL]  = sync_req[2];
  assign cause_req[C_HOT_TS]    = sync_req[3];
  assign cause_req[C_HOT_DL]    = sync_req[4];
  assign cause_req[C_UP_SBR]    = sync_req[5];
  assign cause_req[C_DN_SBR]    = |dn_sync;

  rcr_prio_pick #(.N(NCAUSE)) u_pick (
    .req (cause_req),
    .hit (arb_hit),
    .idx (arb_idx)
  );

  rcr_out_stage #(.NPORTS(NPORTS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_hit   (arb_hit),
    .arb_idx   (arb_idx),
    .mode_vec  (mode_qual),
    .dn_vec    (dn_sync),
    .valid_q   (win_valid),
    .cause_q   (cause_q),
    .type_q    (type_q),
    .scope_q   (scope_q),
    .ports_q   (port_rst),
    .sticky_q  (sticky_clr),
    .tchg_q    (type_chg),
    .type_edge (type_edge),
    .dev_entry (dev_entry)
  );

  assign win_cause = 3'(cause_q);
  assign rst_type  = type_q;
  assign rst_scope = scope_q;

endmodule

// File: rtl/rcr_checker.sv
module rcr_checker #(
  parameter int unsigned NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cause_req,
  input logic              win_valid,
  input logic [2:0]        win_cause,
  input logic [1:0]        rst_type,
  input logic [1:0]        rst_scope,
  input logic [NPORTS-1:0] port_rst,
  input logic              sticky_clr,
  input logic              type_chg
);

  logic [7:0] req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= '0;
    else        req_d <= cause_req;
  end

  a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == (|req_d));

  a_r1_winner_strongest: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (req_d[win_cause] && ((req_d & ((8'd1 << win_cause) - 8'd1)) == 8'd0)));

  a_r2_fund_type: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_cause <= 3'd3) |-> rst_type == 2'b01);

  a_r2_hot_type: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && (win_cause == 3'd4 || win_cause == 3'd5)) |-> rst_type == 2'b10);

  a_r3_wide_scope_all_ports: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && rst_scope != 2'b01) |-> (&port_rst));

  a_r6_same_type_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && $past(win_valid) && rst_type == $past(rst_type)) |-> !type_chg);

  a_r7_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    type_chg |-> (rst_type != $past(rst_type)));

  a_r8_no_pulse_at_edges: assert property (@(posedge clk) disable iff (!rst_n)
    type_chg |-> (win_valid && $past(win_valid)));

  a_r9_sticky_only_dev_entry: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_clr |-> (win_valid && win_cause == 3'd0
                    && !($past(win_valid) && $past(win_cause) == 3'd0)));

  a_r10_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (rst_type == 2'b00 && rst_scope == 2'b00 && port_rst == '0
                    && !sticky_clr && !type_chg));

endmodule

bind rst_cause_resolver rcr_checker #(.NPORTS(NPORTS)) u_rcr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cause_req  (cause_req),
  .win_valid  (win_valid),
  .win_cause  (win_cause),
  .rst_type   (rst_type),
  .rst_scope  (rst_scope),
  .port_rst   (port_rst),
  .sticky_clr (sticky_clr),
  .type_chg   (type_chg)
);

// File: tb/test_rst_cause_resolver.sv
`timescale 1ns/1ps
module test_rst_cause_resolver;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dev_fund_req = 1'b0;
  logic [NP-1:0] port_mode_chg = '0;
  logic [NP-1:0] port_mode_rst_sel = '0;
  logic          part_pin_req = 1'b0;
  logic          part_ctl_req = 1'b0;
  logic          hot_ts_req = 1'b0;
  logic          hot_dl_req = 1'b0;
  logic          up_sbr_req = 1'b0;
  logic [NP-1:0] dn_sbr_req = '0;
  logic          win_valid;
  logic [2:0]    win_cause;
  logic [1:0]    rst_type;
  logic [1:0]    rst_scope;
  logic [NP-1:0] port_rst;
  logic          sticky_clr;
  logic          type_chg;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rst_cause_resolver #(.NPORTS(NP), .SYNC_STAGES(2)) i_rst_cause_resolver (
    .clk(clk), .rst_n(rst_n), .dev_fund_req(dev_fund_req),
    .port_mode_chg(port_mode_chg), .port_mode_rst_sel(port_mode_rst_sel),
    .part_pin_req(part_pin_req), .part_ctl_req(part_ctl_req),
    .hot_ts_req(hot_ts_req), .hot_dl_req(hot_dl_req), .up_sbr_req(up_sbr_req),
    .dn_sbr_req(dn_sbr_req), .win_valid(win_valid), .win_cause(win_cause),
    .rst_type(rst_type), .rst_scope(rst_scope), .port_rst(port_rst),
    .sticky_clr(sticky_clr), .type_chg(type_chg)
  );

  // expectations restated from the requirements
  function automatic int e_idx(logic [7:0] c);
    for (int i = 0; i < 8; i++) if (c[i]) return i;
    return -1;
  endfunction

  function automatic int e_type(int i);
    if (i < 0) return 0;
    if (i <= 3) return 1;
    if (i <= 5) return 2;
    return 3;
  endfunction

  function automatic int e_scope(int i);
    if (i < 0) return 0;
    if (i == 0) return 3;
    if (i == 1 || i == 7) return 1;
    return 2;
  endfunction

  function automatic int e_ports(int i, logic [NP-1:0] mv, logic [NP-1:0] dv);
    if (i < 0) return 0;
    if (i == 1) return int'(mv);
    if (i == 7) return int'(dv);
    return (1 << NP) - 1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] c, logic [NP-1:0] mv, logic [NP-1:0] dv);
    dev_fund_req      = c[0];
    port_mode_chg     = c[1] ? mv : '0;
    port_mode_rst_sel = c[1] ? mv : '0;
    part_pin_req      = c[2];
    part_ctl_req      = c[3];
    hot_ts_req        = c[4];
    hot_dl_req        = c[5];
    up_sbr_req        = c[6];
    dn_sbr_req        = c[7] ? dv : '0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_all(string req, logic [7:0] c, logic [NP-1:0] mv, logic [NP-1:0] dv);
    int w;
    w = e_idx(c);
    chk(req, "win_valid", int'(win_valid), (w >= 0) ? 1 : 0);
    if (w >= 0) chk(req, "win_cause", int'(win_cause), w);
    chk(req, "rst_type", int'(rst_type), e_type(w));
    chk(req, "rst_scope", int'(rst_scope), e_scope(w));
    chk(req, "port_rst", int'(port_rst), e_ports(w, mv, dv));
  endtask

  task automatic go_idle();
    drive(8'h00, '0, '0);
    settle();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R10", "valid in reset", int'(win_valid), 0);
    chk("R10", "type in reset", int'(rst_type), 0);
    chk("R10", "ports in reset", int'(port_rst), 0);
  endtask

  task automatic t_each_cause();
    for (int i = 0; i < 8; i++) begin
      drive(8'(1 << i), 4'b0101, 4'b0010);
      settle();
      expect_all("R2 R3 single", 8'(1 << i), 4'b0101, 4'b0010);
      chk("R9", "sticky on entry", int'(sticky_clr), (i == 0) ? 1 : 0);
      chk("R8", "type_chg on entry", int'(type_chg), 0);
      @(negedge clk);
      chk("R9", "sticky one cycle", int'(sticky_clr), 0);
      go_idle();
    end
  endtask

  task automatic t_priority_cascade();
    logic [7:0] c;
    int prev_t;
    int now_t;
    c = 8'hFF;
    drive(c, 4'b1000, 4'b0110);
    settle();
    expect_all("R1 all", c, 4'b1000, 4'b0110);
    for (int i = 0; i < 7; i++) begin
      prev_t = e_type(e_idx(c));
      c[i] = 1'b0;
      drive(c, 4'b1000, 4'b0110);
      settle();
      now_t = e_type(e_idx(c));
      expect_all("R1 cascade", c, 4'b1000, 4'b0110);
      chk("R7", "type_chg at handover", int'(type_chg), (prev_t != now_t) ? 1 : 0);
      chk("R9", "no sticky on lower", int'(sticky_clr), 0);
    end
    go_idle();
  endtask

  task automatic t_same_type_hold(logic [7:0] both, logic [7:0] rest, int ty);
    drive(both, '0, '0);
    settle();
    drive(rest, '0, '0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R6", "valid held", int'(win_valid), 1);
      chk("R6", "type held", int'(rst_type), ty);
      chk("R6", "no type_chg", int'(type_chg), 0);
    end
    chk("R6", "cause handed", int'(win_cause), e_idx(rest));
    go_idle();
  endtask

  task automatic t_type_switch();
    drive(8'h90, '0, 4'b1001);
    settle();
    chk("R8", "hot entry no pulse", int'(type_chg), 0);
    chk("R2", "hot type", int'(rst_type), 2);
    drive(8'h80, '0, 4'b1001);
    settle();
    chk("R7", "type now sbr", int'(rst_type), 3);
    chk("R7", "pulse high", int'(type_chg), 1);
    chk("R3", "port vector", int'(port_rst), 9);
    @(negedge clk);
    chk("R7", "pulse one cycle", int'(type_chg), 0);
    drive(8'h00, '0, '0);
    settle();
    chk("R8", "release no pulse", int'(type_chg), 0);
    chk("R11", "idle after release", int'(win_valid), 0);
    chk("R11", "ports after release", int'(port_rst), 0);
    @(negedge clk);
  endtask

  task automatic t_mode_qualify();
    port_mode_chg = 4'b0110;
    port_mode_rst_sel = 4'b0000;
    settle();
    chk("R4", "unqualified valid", int'(win_valid), 0);
    chk("R4", "unqualified ports", int'(port_rst), 0);
    port_mode_rst_sel = 4'b0011;
    settle();
    chk("R4", "qualified cause", int'(win_cause), 1);
    chk("R4", "qualified ports", int'(port_rst), 2);
    chk("R4", "qualified scope", int'(rst_scope), 1);
    go_idle();
  endtask

  task automatic t_latency();
    hot_dl_req = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R5", "not before third edge", int'(win_valid), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R5", "after third edge", int'(win_valid), 1);
    chk("R5", "cause", int'(win_cause), 5);
    go_idle();
  endtask

  task automatic t_sticky_preempt();
    drive(8'h04, '0, '0);
    settle();
    drive(8'h05, '0, '0);
    settle();
    chk("R9", "pre-empt pulse", int'(sticky_clr), 1);
    chk("R6", "fund kept no pulse", int'(type_chg), 0);
    @(negedge clk);
    chk("R9", "pre-empt one cycle", int'(sticky_clr), 0);
    drive(8'h04, '0, '0);
    settle();
    chk("R9", "no pulse on leave", int'(sticky_clr), 0);
    chk("R6", "handed to pin", int'(win_cause), 2);
    go_idle();
  endtask

  task automatic t_reset_midway();
    drive(8'h08, '0, '0);
    settle();
    chk("R10", "active before", int'(win_valid), 1);
    rst_n = 1'b0;
    #1;
    chk("R10", "valid cleared", int'(win_valid), 0);
    chk("R10", "type cleared", int'(rst_type), 0);
    chk("R10", "scope cleared", int'(rst_scope), 0);
    @(negedge clk);
    rst_n = 1'b1;
    go_idle();
  endtask

  initial begin
    #1;
    t_reset_state();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_each_cause();
    t_priority_cascade();
    t_same_type_hold(8'h05, 8'h04, 1);
    t_same_type_hold(8'h30, 8'h20, 2);
    t_type_switch();
    t_mode_qualify();
    t_latency();
    t_sticky_preempt();
    t_reset_midway();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule